// File: doc/BRIEF.md
# Handshaked Parallel Host Slave Port

This block is the slave end of a parallel link between an external host controller and an internal processing core. The host writes commands and compressed stream words into the port and reads result words back. Its pins are an asynchronous active-low strobe, a read/write select and an 8-bit data bus, split into an input half and an output half with an output enable. Two active-low status lines tell the host when a write may be issued and when a read word is waiting. On the core side, the block offers a receive word with a valid/ready pair and a command/data tag, a transmit word with a valid/ready pair, a request to enter the wide transfer width, and an end-of-phrase pulse.

The host strobe and select pass through two-flop synchronizers into the system clock. The rising edge of the synchronized strobe ends each transfer. In narrow mode only the low nibble carries payload, and bus bit 4 tags each written word as a command (low) or stream data (high). In wide mode all eight bits are payload and every word is stream data, so commands cannot reach the core while a phrase plays. An end-of-phrase pulse returns the port to narrow mode. The system clock must be fast enough to take at least two samples inside the host's 300 ns minimum strobe-low time.

Top module: `host_parallel_port`

## Requirements
- R1: After reset, host_in_busy is 0 (ready), host_out_busy is 1, host_bus_oe is 0, rx_valid is 0, tx_ready is 1, proto_err is 0 and wide_mode is 0 (narrow).
- R2: In narrow mode, a write (host_rw = 0) is captured on the strobe rising edge. rx_word = {4'b0000, bus[3:0]} and rx_is_data = bus[4], where 0 means command and 1 means data. Bits 7..5 are ignored. rx_valid rises on the third clock edge after the strobe rises.
- R3: After a capture, host_in_busy stays 1 and rx_word stays stable until the core takes the word (rx_valid and rx_ready high at a clock edge). On that edge rx_valid and host_in_busy both fall to 0.
- R4: In wide mode, a write captures all 8 bus bits into rx_word, and rx_is_data is always 1 whatever bit 4 is.
- R5: wide_req switches the port to wide mode only when no received word is pending and the synchronized strobe is high. The switch lands on the clock edge after that condition holds. In wide mode, phrase_end returns the port to narrow mode on the next edge. phrase_end has no effect in narrow mode, and wide_req has no effect in wide mode.
- R6: tx_ready is 1 while no transmit word is held. A word loaded with tx_valid and tx_ready drives host_out_busy to 0 on that edge.
- R7: host_bus_oe is 1 only while the synchronized strobe is low, the synchronized select reads high and a transmit word is held. It rises on the third clock edge after the strobe falls. While it is 1, host_bus_o carries the full word in wide mode and {4'b0000, word[3:0]} in narrow mode.
- R8: The strobe rising edge that ends a read frees the transmit word. On the third clock edge after the strobe rises, host_out_busy returns to 1, tx_ready to 1 and host_bus_oe to 0.
- R9: A write strobe while host_in_busy is 1 is ignored and leaves rx_word unchanged. A read strobe while host_out_busy is 1 never enables the bus. Either one sets proto_err.
- R10: proto_err stays 1 until reset.
- R11: host_bus_oe stays 0 whenever the synchronized select is low, even with a transmit word held and the strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_stb_n | input | 1 | Asynchronous host strobe, active low |
| host_rw | input | 1 | Host select: 1 read, 0 write |
| host_bus_i | input | BUS_W | Data bus as driven by the host |
| host_bus_o | output | BUS_W | Data bus value driven by the port |
| host_bus_oe | output | 1 | Output enable for host_bus_o |
| host_in_busy | output | 1 | Low when the port accepts a write |
| host_out_busy | output | 1 | Low when a read word is waiting |
| rx_valid | output | 1 | Received word available to the core |
| rx_ready | input | 1 | Core takes the received word |
| rx_word | output | BUS_W | Received word |
| rx_is_data | output | 1 | 1 stream data, 0 command |
| tx_valid | input | 1 | Core offers a word for the host |
| tx_ready | output | 1 | Port can take a transmit word |
| tx_word | input | BUS_W | Word for the host |
| wide_req | input | 1 | Request to enter wide mode |
| phrase_end | input | 1 | Pulse: wide phrase finished |
| wide_mode | output | 1 | 1 while in wide mode |
| proto_err | output | 1 | Sticky handshake violation flag |

## Verification
Writes are tried with command-tagged and data-tagged nibbles carrying junk in the top bits, and then with bytes in wide mode whose bit 4 is low. Together these separate correct tag decoding from mode-blind capture. A wide request is raised while a word is still pending, so the bench can show that the switch waits for the buffer to drain. Reads are driven in both widths to expose the nibble masking. A strobe with the select low and a word held shows that the port never drives the bus on a write. Strobes against a busy line in each direction exercise the error flag and its stickiness.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

  typedef enum logic {
    WM_NARROW = 1'b0,
    WM_WIDE   = 1'b1
  } width_mode_e;

  // Strobe end events, split by the select sampled with them
  typedef struct packed {
    logic wr_rise;
    logic rd_rise;
  } stb_evt_t;

endpackage

// File: rtl/hpp_sync.sv
module hpp_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hpp_strobe_edge.sv
module hpp_strobe_edge
  import hpp_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_s,
  input  logic             rw_s,
  input  logic [BUS_W-1:0] bus_i,
  output stb_evt_t         evt,
  output logic [BUS_W-1:0] bus_q
);

  logic stb_d;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) stb_d <= 1'b1;
    else     stb_d <= stb_s;
  end

  assign rise        = stb_s & ~stb_d;
  assign evt.wr_rise = rise & ~rw_s;
  assign evt.rd_rise = rise & rw_s;

  // Bus follows the pins while the strobe is low; frozen once it rises
  always_ff @(posedge clk) begin
    if (rst)         bus_q <= '0;
    else if (!stb_s) bus_q <= bus_i;
  end

endmodule

// File: rtl/hpp_rx_path.sv
module hpp_rx_path
  import hpp_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int NARROW_W = 4,
  parameter int TAG_BIT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_rise,
  input  logic             stb_s,
  input  logic [BUS_W-1:0] bus_q,
  input  logic             wide_req,
  input  logic             phrase_end,
  input  logic             rx_ready,
  output logic             rx_valid,
  output logic [BUS_W-1:0] rx_word,
  output logic             rx_is_data,
  output logic             in_busy,
  output logic             wr_err,
  output width_mode_e      mode
);

  logic             rx_full;
  logic             accept;
  logic             may_widen;
  logic [BUS_W-1:0] narrow_word;

  assign accept      = wr_rise & ~rx_full;
  assign wr_err      = wr_rise & rx_full;
  assign narrow_word = BUS_W'(bus_q[NARROW_W-1:0]);
  assign may_widen   = wide_req & ~rx_full & stb_s & ~wr_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full    <= 1'b0;
      rx_word    <= '0;
      rx_is_data <= 1'b0;
    end else begin
      if (rx_full && rx_ready) rx_full <= 1'b0;
      if (accept) begin
        rx_full    <= 1'b1;
        rx_word    <= (mode == WM_WIDE) ? bus_q : narrow_word;
        rx_is_data <= (mode == WM_WIDE) ? 1'b1 : bus_q[TAG_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= WM_NARROW;
    end else if (mode == WM_WIDE) begin
      if (phrase_end) mode <= WM_NARROW;
    end else if (may_widen) begin
      mode <= WM_WIDE;
    end
  end

  assign rx_valid = rx_full;
  assign in_busy  = rx_full;

  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_word) && $stable(rx_is_data));

  assert_cmd_only_narrow_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_is_data |-> mode == WM_NARROW);

  assert_no_widen_pending_R5: assert property (@(posedge clk) disable iff (rst)
    mode == WM_NARROW && rx_full |=> mode == WM_NARROW);

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    wr_err && !rx_ready |=> $stable(rx_word) && rx_valid);

endmodule

// File: rtl/hpp_tx_path.sv
module hpp_tx_path
  import hpp_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int NARROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_valid,
  input  logic [BUS_W-1:0] tx_word,
  input  logic             rd_rise,
  input  logic             stb_s,
  input  logic             rw_s,
  input  width_mode_e      mode,
  output logic             tx_ready,
  output logic             out_busy,
  output logic [BUS_W-1:0] bus_o,
  output logic             bus_oe,
  output logic             rd_err
);

  logic             tx_full;
  logic [BUS_W-1:0] tx_data;
  logic [BUS_W-1:0] shaped;

  assign tx_ready = ~tx_full;
  assign out_busy = ~tx_full;
  assign rd_err   = rd_rise & ~tx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full <= 1'b0;
      tx_data <= '0;
    end else begin
      if (rd_rise && tx_full) tx_full <= 1'b0;
      if (tx_valid && !tx_full) begin
        tx_full <= 1'b1;
        tx_data <= tx_word;
      end
    end
  end

  // Upper lines carry payload only in wide mode
  for (genvar i = 0; i < BUS_W; i++) begin : g_lane
    if (i < NARROW_W) begin : g_low
      assign shaped[i] = tx_data[i];
    end else begin : g_high
      assign shaped[i] = tx_data[i] & (mode == WM_WIDE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_o  <= '0;
      bus_oe <= 1'b0;
    end else begin
      bus_o  <= shaped;
      bus_oe <= rw_s & ~stb_s & tx_full;
    end
  end

  assert_load_sets_ready_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> !out_busy);

  assert_drive_needs_word_R7: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !out_busy);

  assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (rst)
    !rw_s |=> !bus_oe);

  assert_read_end_frees_R8: assert property (@(posedge clk) disable iff (rst)
    rd_rise && !tx_valid |=> out_busy && tx_ready);

endmodule

// File: rtl/host_parallel_port.sv
module host_parallel_port
  import hpp_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int NARROW_W    = 4,
  parameter int TAG_BIT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_stb_n,
  input  logic             host_rw,
  input  logic [BUS_W-1:0] host_bus_i,
  output logic [BUS_W-1:0] host_bus_o,
  output logic             host_bus_oe,
  output logic             host_in_busy,
  output logic             host_out_busy,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [BUS_W-1:0] rx_word,
  output logic             rx_is_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [BUS_W-1:0] tx_word,
  input  logic             wide_req,
  input  logic             phrase_end,
  output logic             wide_mode,
  output logic             proto_err
);

  localparam logic [1:0] CTRL_IDLE = 2'b10;  // strobe high, select write

  logic [1:0]       ctrl_s;
  logic             stb_s;
  logic             rw_s;
  stb_evt_t         evt;
  logic [BUS_W-1:0] bus_q;
  logic             wr_err;
  logic             rd_err;
  width_mode_e      mode;

  hpp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_stb_n, host_rw}),
    .q   (ctrl_s)
  );

  assign stb_s = ctrl_s[1];
  assign rw_s  = ctrl_s[0];

  hpp_strobe_edge #(.BUS_W(BUS_W)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .stb_s (stb_s),
    .rw_s  (rw_s),
    .bus_i (host_bus_i),
    .evt   (evt),
    .bus_q (bus_q)
  );

  hpp_rx_path #(.BUS_W(BUS_W), .NARROW_W(NARROW_W), .TAG_BIT(TAG_BIT)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .wr_rise    (evt.wr_rise),
    .stb_s      (stb_s),
    .bus_q      (bus_q),
    .wide_req   (wide_req),
    .phrase_end (phrase_end),
    .rx_ready   (rx_ready),
    .rx_valid   (rx_valid),
    .rx_word    (rx_word),
    .rx_is_data (rx_is_data),
    .in_busy    (host_in_busy),
    .wr_err     (wr_err),
    .mode       (mode)
  );

  hpp_tx_path #(.BUS_W(BUS_W), .NARROW_W(NARROW_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_word  (tx_word),
    .rd_rise  (evt.rd_rise),
    .stb_s    (stb_s),
    .rw_s     (rw_s),
    .mode     (mode),
    .tx_ready (tx_ready),
    .out_busy (host_out_busy),
    .bus_o    (host_bus_o),
    .bus_oe   (host_bus_oe),
    .rd_err   (rd_err)
  );

  always_ff @(posedge clk) begin
    if (rst)                  proto_err <= 1'b0;
    else if (wr_err || rd_err) proto_err <= 1'b1;
  end

  assign wide_mode = (mode == WM_WIDE);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  assert_err_flagged_R9: assert property (@(posedge clk) disable iff (rst)
    wr_err || rd_err |=> proto_err);

  assert_phrase_end_narrows_R5: assert property (@(posedge clk) disable iff (rst)
    wide_mode && phrase_end |=> !wide_mode);

endmodule

// File: tb/host_parallel_port_tb.sv
module host_parallel_port_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_stb_n = 1'b1;
  logic       host_rw = 1'b0;
  logic [7:0] host_bus_i = '0;
  logic [7:0] host_bus_o;
  logic       host_bus_oe;
  logic       host_in_busy;
  logic       host_out_busy;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_word;
  logic       rx_is_data;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_word = '0;
  logic       wide_req = 1'b0;
  logic       phrase_end = 1'b0;
  logic       wide_mode;
  logic       proto_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  host_parallel_port dut_i (
    .clk (clk), .rst (rst),
    .host_stb_n (host_stb_n), .host_rw (host_rw),
    .host_bus_i (host_bus_i), .host_bus_o (host_bus_o), .host_bus_oe (host_bus_oe),
    .host_in_busy (host_in_busy), .host_out_busy (host_out_busy),
    .rx_valid (rx_valid), .rx_ready (rx_ready), .rx_word (rx_word), .rx_is_data (rx_is_data),
    .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_word (tx_word),
    .wide_req (wide_req), .phrase_end (phrase_end),
    .wide_mode (wide_mode), .proto_err (proto_err)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
  endtask

  // Full strobe pulse; returns on the negedge where the strobe rises
  task automatic strobe(logic rw, logic [7:0] v, int low_cycles);
    host_rw    = rw;
    host_bus_i = v;
    tick(1);
    host_stb_n = 1'b0;
    tick(low_cycles);
    host_stb_n = 1'b1;
  endtask

  task automatic consume(string req);
    rx_ready = 1'b1;
    tick(1);
    rx_ready = 1'b0;
    chk(req, "rx_valid after take", rx_valid, 0);
    chk(req, "in_busy after take", host_in_busy, 0);
  endtask

  task automatic load_tx(string req, logic [7:0] v);
    tx_word  = v;
    tx_valid = 1'b1;
    tick(1);
    tx_valid = 1'b0;
    chk(req, "out_busy after load", host_out_busy, 0);
    chk(req, "tx_ready after load", tx_ready, 0);
  endtask

  task automatic t_reset();
    chk("R1", "in_busy", host_in_busy, 0);
    chk("R1", "out_busy", host_out_busy, 1);
    chk("R1", "bus_oe", host_bus_oe, 0);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "tx_ready", tx_ready, 1);
    chk("R1", "proto_err", proto_err, 0);
    chk("R1", "wide_mode", wide_mode, 0);
  endtask

  task automatic t_narrow_write(logic [7:0] v, logic [7:0] exp_w, logic exp_tag);
    strobe(1'b0, v, 5);
    tick(2);
    chk("R2", "rx_valid before third edge", rx_valid, 0);
    tick(1);
    host_bus_i = 8'hFF;
    chk("R2", "rx_valid", rx_valid, 1);
    chk("R2", "rx_word", rx_word, exp_w);
    chk("R2", "rx_is_data", rx_is_data, exp_tag);
    chk("R3", "in_busy after capture", host_in_busy, 1);
    tick(4);
    chk("R3", "rx_word held", rx_word, exp_w);
    chk("R3", "in_busy held", host_in_busy, 1);
    consume("R3");
  endtask

  task automatic t_mode_gate();
    phrase_end = 1'b1;
    tick(1);
    phrase_end = 1'b0;
    chk("R5", "phrase_end in narrow", wide_mode, 0);
    strobe(1'b0, 8'h5F, 5);
    tick(3);
    chk("R2", "pending word", rx_word, 8'h0F);
    wide_req = 1'b1;
    tick(3);
    chk("R5", "no widen while pending", wide_mode, 0);
    consume("R5");
    chk("R5", "widen one edge after drain", wide_mode, 0);
    tick(1);
    chk("R5", "widened", wide_mode, 1);
    wide_req = 1'b0;
  endtask

  task automatic t_wide_write(logic [7:0] v);
    strobe(1'b0, v, 5);
    tick(3);
    chk("R4", "wide rx_valid", rx_valid, 1);
    chk("R4", "wide rx_word", rx_word, v);
    chk("R4", "wide rx_is_data", rx_is_data, 1);
    consume("R4");
  endtask

  task automatic t_read(logic [7:0] v, logic [7:0] exp_bus);
    load_tx("R6", v);
    host_rw = 1'b1;
    tick(1);
    host_stb_n = 1'b0;
    tick(2);
    chk("R7", "oe before third edge", host_bus_oe, 0);
    tick(1);
    chk("R7", "oe during read", host_bus_oe, 1);
    chk("R7", "bus_o", host_bus_o, exp_bus);
    tick(2);
    host_stb_n = 1'b1;
    tick(2);
    chk("R8", "oe until third edge", host_bus_oe, 1);
    tick(1);
    chk("R8", "oe after read", host_bus_oe, 0);
    chk("R8", "out_busy after read", host_out_busy, 1);
    chk("R8", "tx_ready after read", tx_ready, 1);
    host_rw = 1'b0;
    tick(1);
  endtask

  task automatic t_rw_low();
    load_tx("R6", 8'h9B);
    host_rw    = 1'b0;
    host_bus_i = 8'h12;
    tick(1);
    host_stb_n = 1'b0;
    tick(3);
    chk("R11", "oe with select low", host_bus_oe, 0);
    tick(3);
    chk("R11", "oe still low", host_bus_oe, 0);
    host_stb_n = 1'b1;
    tick(3);
    chk("R11", "write captured", rx_word, 8'h02);
    chk("R11", "tx word kept", host_out_busy, 0);
    consume("R3");
  endtask

  task automatic t_err_write();
    strobe(1'b0, 8'h3A, 5);
    tick(3);
    chk("R2", "first word", rx_word, 8'h0A);
    strobe(1'b0, 8'h17, 5);
    tick(3);
    chk("R9", "busy write flagged", proto_err, 1);
    chk("R9", "busy write ignored", rx_word, 8'h0A);
    chk("R9", "tag unchanged", rx_is_data, 1);
    consume("R9");
    tick(5);
    chk("R10", "flag sticky", proto_err, 1);
    do_reset();
    chk("R10", "flag cleared by reset", proto_err, 0);
  endtask

  task automatic t_err_read();
    host_rw = 1'b1;
    tick(1);
    host_stb_n = 1'b0;
    tick(4);
    chk("R9", "no drive on empty read", host_bus_oe, 0);
    host_stb_n = 1'b1;
    tick(3);
    chk("R9", "empty read flagged", proto_err, 1);
    chk("R9", "out_busy stays", host_out_busy, 1);
    host_rw = 1'b0;
    tick(5);
    chk("R10", "flag still set", proto_err, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_narrow_write(8'hE5, 8'h05, 1'b0);
    t_narrow_write(8'h3A, 8'h0A, 1'b1);
    t_mode_gate();
    t_wide_write(8'hA5);
    t_wide_write(8'h0F);
    wide_req = 1'b1;
    tick(2);
    wide_req = 1'b0;
    chk("R5", "wide_req in wide", wide_mode, 1);
    t_read(8'hC6, 8'hC6);
    phrase_end = 1'b1;
    tick(1);
    phrase_end = 1'b0;
    chk("R5", "phrase_end narrows", wide_mode, 0);
    t_read(8'hC6, 8'h06);
    t_rw_low();
    host_rw = 1'b1;
    tick(1);
    host_stb_n = 1'b0;
    tick(3);
    chk("R7", "narrow read after rw test", host_bus_o, 8'h0B);
    host_stb_n = 1'b1;
    tick(3);
    host_rw = 1'b0;
    chk("R8", "freed", host_out_busy, 1);
    t_err_write();
    t_err_read();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule